// File: doc/BRIEF.md
# Scatter-gather bus-master DMA engine

This block moves data between a disk-style device and system memory on behalf of a host driver. The driver builds a table of 8-byte descriptors in memory. Each descriptor names a 16-bit aligned region and its length. The driver writes the table pointer into a small register window, picks a direction, and starts the engine. The engine then walks the table on its own: it reads each descriptor through the memory port, streams the region one 16-bit word at a time between memory and the device handshake, and stops after the descriptor whose end flag is set.

Completion is signalled by the device's interrupt line. A clean finish needs two things to coincide: the table has been used up and the device has interrupted. If only one of them happens, the engine reports an error. The driver reads the outcome from a status byte and acknowledges it by writing ones to the flag bits.

The register window is eight bytes wide. The command byte sits at offset 0, the status byte at offset 2 and the 32-bit table pointer at offset 4. Reads return data one clock after the address is presented.

Top module: `sgdma_engine`

## Requirements
- R1: Offset 0 reads back the command byte (bit 0 run, bit 3 direction). Offset 4 holds the table pointer, whose two low bits always read as zero, so descriptor fetches are word aligned.
- R2: Writing command bit 0 from 0 to 1 sets status bit 0 (active). The first descriptor is then read as two 32-bit reads at the pointer and at the pointer plus 4.
- R3: In a descriptor, word 0 is the region address and bits 15:0 of word 1 are the byte count, where 0 stands for 65536 bytes. Exactly count/2 words are moved for the region.
- R4: With command bit 3 = 1, words taken from the device are written to memory as half-word writes at consecutive rising addresses.
- R5: With command bit 3 = 0, half-words read from memory are offered to the device in address order. An offered word is held stable until the device accepts it.
- R6: After a descriptor without bit 31 of word 1 set, the next descriptor is fetched 8 bytes further on. The engine moves nothing after the descriptor with bit 31 set.
- R7: When the table is used up and the device then interrupts, active clears and status bit 2 sets. Status bits 2:0 then read as binary 100.
- R8: A device interrupt while descriptors or data remain clears active and sets status bit 1.
- R9: When the table is used up and no interrupt arrives within IRQ_WAIT cycles, active clears and status bit 1 sets.
- R10: Writing a 1 to status bit 1 or bit 2 clears that bit. Writing 0 leaves it unchanged.
- R11: Writing command bit 0 from 1 to 0 aborts at once. Active clears, memory and device requests drop, and no flag is set.
- R12: Status bit 7 reads as the SIMPLEX parameter.
- R13: A memory request holds its address and type until the memory acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset in the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_half | output | 1 | 1 = 16-bit data access, 0 = 32-bit descriptor read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data, low 16 bits used |
| mem_ack | input | 1 | Memory acknowledge; carries read data |
| mem_rdata | input | 32 | Read data valid with mem_ack |
| dev_rd_valid | input | 1 | Device offers a word (device-to-memory) |
| dev_rd_data | input | WORD_W | Offered device word |
| dev_rd_ready | output | 1 | Engine accepts a device word |
| dev_wr_valid | output | 1 | Engine offers a word (memory-to-device) |
| dev_wr_data | output | WORD_W | Word for the device |
| dev_wr_ready | input | 1 | Device accepts the word |
| dev_irq | input | 1 | Device interrupt |

## Verification
Two outcomes are hard to reach from the ports. One is a count-0 descriptor, which moves 65536 bytes. The bench places it at address 0 of a mirrored memory model, always accepts on the device side, and compares the word total and a running sum against the model's contents. The other is the tail window, where the timing of the device interrupt decides between success, early error and timeout. The bench detects the moment the last word is moved at the memory or device boundary and raises the interrupt a fixed number of cycles later. It also raises it before any data moves, and withholds it entirely. Sweeps over region lengths, memory wait states and device back-pressure in both directions cover the handshake-holding rules.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int BUS_W      = 32;
  localparam int DESC_CNT_W = 16;
  localparam int LAST_BIT   = 31;

  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_PTR  = 3'd4;

  localparam int CMD_RUN  = 0;
  localparam int CMD_DIR  = 3;
  localparam int ST_ACT   = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_IRQ   = 2;
  localparam int ST_SPLX  = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH_A, S_FETCH_B, S_DEV_IN, S_MEM_WR, S_MEM_RD, S_DEV_OUT, S_TAIL
  } walk_state_t;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit SIMPLEX = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic              fin_ok,
  input  logic              fin_err,
  output logic              go,
  output logic              halt,
  output logic              go_dir,
  output logic [ADDR_W-1:0] tbl_base,
  output logic              flag_irq,
  output logic              flag_err,
  output logic [BUS_W-1:0]  reg_rdata
);
  logic              run_q, dir_q;
  logic [ADDR_W-3:0] base_q;
  logic              wr_cmd, wr_stat, wr_ptr;
  logic [7:0]        stat_byte, cmd_byte;

  assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
  assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
  assign wr_ptr  = reg_wr && (reg_addr == OFS_PTR);

  // start and abort are edges of the run bit
  assign go       = wr_cmd &&  reg_wdata[CMD_RUN] && !run_q;
  assign halt     = wr_cmd && !reg_wdata[CMD_RUN] &&  run_q;
  assign go_dir   = reg_wdata[CMD_DIR];
  assign tbl_base = {base_q, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      dir_q    <= 1'b0;
      base_q   <= '0;
      flag_irq <= 1'b0;
      flag_err <= 1'b0;
    end else begin
      if (wr_cmd) begin
        run_q <= reg_wdata[CMD_RUN];
        dir_q <= reg_wdata[CMD_DIR];
      end
      if (wr_ptr) base_q <= reg_wdata[ADDR_W-1:2];
      // a new event wins over a simultaneous acknowledge
      flag_irq <= fin_ok  | (flag_irq & ~(wr_stat & reg_wdata[ST_IRQ]));
      flag_err <= fin_err | (flag_err & ~(wr_stat & reg_wdata[ST_ERR]));
    end
  end

  always_comb begin
    cmd_byte          = '0;
    cmd_byte[CMD_RUN] = run_q;
    cmd_byte[CMD_DIR] = dir_q;
    stat_byte          = '0;
    stat_byte[ST_ACT]  = busy;
    stat_byte[ST_ERR]  = flag_err;
    stat_byte[ST_IRQ]  = flag_irq;
    stat_byte[ST_SPLX] = SIMPLEX;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        OFS_CMD:  reg_rdata <= BUS_W'(cmd_byte);
        OFS_STAT: reg_rdata <= BUS_W'(stat_byte);
        OFS_PTR:  reg_rdata <= BUS_W'(tbl_base);
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 16,
  parameter int IRQ_WAIT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              halt,
  input  logic              go_dir,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              mem_ack,
  input  logic [BUS_W-1:0]  mem_rdata,
  input  logic              dev_rd_valid,
  input  logic [WORD_W-1:0] dev_rd_data,
  input  logic              dev_wr_ready,
  input  logic              dev_irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_half,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BUS_W-1:0]  mem_wdata,
  output logic              dev_rd_ready,
  output logic              dev_wr_valid,
  output logic [WORD_W-1:0] dev_wr_data,
  output logic              busy,
  output logic              fin_ok,
  output logic              fin_err
);
  localparam int STEP  = WORD_W / 8;
  localparam int CNT_W = DESC_CNT_W + 1;
  localparam int TMR_W = $clog2(IRQ_WAIT + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << DESC_CNT_W;

  walk_state_t       st;
  logic [ADDR_W-1:0] dptr, baddr;
  logic [CNT_W-1:0]  left;
  logic              last_d, dir_q;
  logic [TMR_W-1:0]  tmr;
  logic              early_irq, step_done, region_end;
  logic              unused_rsvd;

  assign busy        = (st != S_IDLE);
  assign early_irq   = dev_irq && (st != S_IDLE) && (st != S_TAIL);
  assign step_done   = (st == S_MEM_WR) ? mem_ack : dev_wr_ready;
  assign region_end  = (left <= CNT_W'(STEP));
  assign unused_rsvd = ^mem_rdata[LAST_BIT-1:DESC_CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      dptr         <= '0;
      baddr        <= '0;
      left         <= '0;
      last_d       <= 1'b0;
      dir_q        <= 1'b0;
      tmr          <= '0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_half     <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      dev_rd_ready <= 1'b0;
      dev_wr_valid <= 1'b0;
      dev_wr_data  <= '0;
      fin_ok       <= 1'b0;
      fin_err      <= 1'b0;
    end else begin
      fin_ok  <= 1'b0;
      fin_err <= 1'b0;
      if (halt || early_irq) begin
        st           <= S_IDLE;
        mem_req      <= 1'b0;
        dev_rd_ready <= 1'b0;
        dev_wr_valid <= 1'b0;
        fin_err      <= early_irq && !halt;
      end else begin
        case (st)
          S_IDLE: if (go) begin
            dptr     <= tbl_base;
            dir_q    <= go_dir;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_half <= 1'b0;
            mem_addr <= tbl_base;
            st       <= S_FETCH_A;
          end
          S_FETCH_A: if (mem_ack) begin
            baddr    <= mem_rdata[ADDR_W-1:0];
            mem_addr <= dptr + ADDR_W'(4);
            st       <= S_FETCH_B;
          end
          S_FETCH_B: if (mem_ack) begin
            left   <= (mem_rdata[DESC_CNT_W-1:0] == '0) ? FULL_CNT
                                                         : CNT_W'(mem_rdata[DESC_CNT_W-1:0]);
            last_d <= mem_rdata[LAST_BIT];
            dptr   <= dptr + ADDR_W'(8);
            if (dir_q) begin
              mem_req      <= 1'b0;
              dev_rd_ready <= 1'b1;
              st           <= S_DEV_IN;
            end else begin
              mem_half <= 1'b1;
              mem_addr <= baddr;
              st       <= S_MEM_RD;
            end
          end
          S_DEV_IN: if (dev_rd_valid) begin
            dev_rd_ready <= 1'b0;
            mem_req      <= 1'b1;
            mem_we       <= 1'b1;
            mem_half     <= 1'b1;
            mem_addr     <= baddr;
            mem_wdata    <= BUS_W'(dev_rd_data);
            st           <= S_MEM_WR;
          end
          S_MEM_RD: if (mem_ack) begin
            mem_req      <= 1'b0;
            dev_wr_data  <= mem_rdata[WORD_W-1:0];
            dev_wr_valid <= 1'b1;
            st           <= S_DEV_OUT;
          end
          S_MEM_WR, S_DEV_OUT: if (step_done) begin
            mem_req      <= 1'b0;
            mem_we       <= 1'b0;
            dev_wr_valid <= 1'b0;
            baddr        <= baddr + ADDR_W'(STEP);
            left         <= left - CNT_W'(STEP);
            if (region_end) begin
              if (last_d) begin
                tmr <= '0;
                st  <= S_TAIL;
              end else begin
                mem_req  <= 1'b1;
                mem_half <= 1'b0;
                mem_addr <= dptr;
                st       <= S_FETCH_A;
              end
            end else if (dir_q) begin
              dev_rd_ready <= 1'b1;
              st           <= S_DEV_IN;
            end else begin
              mem_req  <= 1'b1;
              mem_half <= 1'b1;
              mem_addr <= baddr + ADDR_W'(STEP);
              st       <= S_MEM_RD;
            end
          end
          S_TAIL: begin
            if (dev_irq) begin
              fin_ok <= 1'b1;
              st     <= S_IDLE;
            end else if (tmr == TMR_W'(IRQ_WAIT - 1)) begin
              fin_err <= 1'b1;
              st      <= S_IDLE;
            end else begin
              tmr <= tmr + TMR_W'(1);
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 16,
  parameter int IRQ_WAIT = 64,
  parameter bit SIMPLEX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_half,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              dev_rd_valid,
  input  logic [WORD_W-1:0] dev_rd_data,
  output logic              dev_rd_ready,
  output logic              dev_wr_valid,
  output logic [WORD_W-1:0] dev_wr_data,
  input  logic              dev_wr_ready,
  input  logic              dev_irq
);
  logic              go, halt, go_dir, busy, fin_ok, fin_err, flag_irq, flag_err;
  logic [ADDR_W-1:0] tbl_base;

  sgdma_regs #(.ADDR_W(ADDR_W), .SIMPLEX(SIMPLEX)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .fin_ok(fin_ok), .fin_err(fin_err), .go(go), .halt(halt),
    .go_dir(go_dir), .tbl_base(tbl_base), .flag_irq(flag_irq), .flag_err(flag_err),
    .reg_rdata(reg_rdata)
  );

  sgdma_walker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .IRQ_WAIT(IRQ_WAIT)) u_walk (
    .clk(clk), .rst(rst), .go(go), .halt(halt), .go_dir(go_dir), .tbl_base(tbl_base),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dev_rd_valid(dev_rd_valid),
    .dev_rd_data(dev_rd_data), .dev_wr_ready(dev_wr_ready), .dev_irq(dev_irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .dev_rd_ready(dev_rd_ready), .dev_wr_valid(dev_wr_valid),
    .dev_wr_data(dev_wr_data), .busy(busy), .fin_ok(fin_ok), .fin_err(fin_err)
  );
endmodule

// File: rtl/sgdma_checker.sv
module sgdma_checker #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_half,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              dev_rd_ready,
  input logic              dev_wr_valid,
  input logic [WORD_W-1:0] dev_wr_data,
  input logic              dev_wr_ready,
  input logic              dev_irq,
  input logic              busy,
  input logic              halt,
  input logic              fin_ok,
  input logic              fin_err,
  input logic              flag_irq,
  input logic              flag_err
);
  a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !halt && !dev_irq |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  a_r5_offer_hold: assert property (@(posedge clk) disable iff (rst)
    dev_wr_valid && !dev_wr_ready && !halt && !dev_irq |=> dev_wr_valid && $stable(dev_wr_data));
  a_r4_half_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_half |-> !mem_addr[0]);
  a_r1_fetch_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_half |-> (mem_addr[1:0] == 2'b00) && !mem_we);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !dev_rd_ready && !dev_wr_valid);
  a_r11_abort_stops: assert property (@(posedge clk) disable iff (rst)
    halt |=> !busy);
  a_r7_done_flag: assert property (@(posedge clk) disable iff (rst)
    fin_ok |=> flag_irq && !busy);
  a_r8_err_flag: assert property (@(posedge clk) disable iff (rst)
    fin_err |=> flag_err && !busy);
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(fin_ok && fin_err));
endmodule

bind sgdma_engine sgdma_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .dev_rd_ready(dev_rd_ready),
  .dev_wr_valid(dev_wr_valid), .dev_wr_data(dev_wr_data), .dev_wr_ready(dev_wr_ready),
  .dev_irq(dev_irq), .busy(busy), .halt(halt), .fin_ok(fin_ok), .fin_err(fin_err),
  .flag_irq(flag_irq), .flag_err(flag_err)
);

// File: tb/sgdma_engine_bench.sv
`timescale 1ns/1ps
module sgdma_engine_bench;
  localparam int IRQ_WAIT = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_half;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        dev_rd_valid = 1'b0;
  logic [15:0] dev_rd_data = '0;
  logic        dev_rd_ready;
  logic        dev_wr_valid;
  logic [15:0] dev_wr_data;
  logic        dev_wr_ready = 1'b0;
  logic        dev_irq = 1'b0;

  sgdma_engine #(.IRQ_WAIT(IRQ_WAIT), .SIMPLEX(1'b1)) u_sgdma_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_rd_valid(dev_rd_valid), .dev_rd_data(dev_rd_data), .dev_rd_ready(dev_rd_ready),
    .dev_wr_valid(dev_wr_valid), .dev_wr_data(dev_wr_data), .dev_wr_ready(dev_wr_ready),
    .dev_irq(dev_irq)
  );

  always #2.5 clk = ~clk;

  logic [15:0] mem [4096];
  int          errors = 0, checks = 0;
  int          rx_n = 0, src_n = 0, wr_n = 0, fetch_n = 0;
  logic [31:0] rx_sum = '0;
  logic [15:0] rx_log [16];
  logic [31:0] fetch_log [8];
  bit          src_en = 1'b0;
  int          snk_mode = 0;
  int          mem_delay = 0, mem_wait = 0;
  logic [31:0] lat_addr = '0;
  logic [11:0] idx;
  bit          tog = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one acknowledge per request after mem_delay wait cycles, mirrored every 8 KB
  always @(negedge clk) begin
    if (rst) begin
      mem_ack  = 1'b0;
      mem_wait = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (!mem_req) begin
      mem_wait = 0;
    end else if (mem_wait < mem_delay) begin
      if (mem_wait == 0) lat_addr = mem_addr;
      mem_wait++;
    end else begin
      if (mem_delay > 0) check("R13 request address held while waiting", mem_addr, lat_addr);
      mem_wait = 0;
      mem_ack  = 1'b1;
      idx      = mem_addr[12:1];
      if (mem_we) begin
        mem[idx] = mem_wdata[15:0];
        wr_n++;
      end else begin
        mem_rdata = {mem[idx + 12'd1], mem[idx]};
        if (!mem_half && fetch_n < 8) begin
          fetch_log[fetch_n] = mem_addr;
          fetch_n++;
        end
      end
    end
  end

  // device source and sink
  always @(negedge clk) begin
    dev_rd_valid = src_en;
    dev_rd_data  = 16'hA000 + 16'(src_n);
    if (dev_rd_valid && dev_rd_ready) src_n++;
    tog = ~tog;
    dev_wr_ready = (snk_mode == 0) ? 1'b1 : (snk_mode == 1) ? tog : 1'b0;
    if (dev_wr_valid && dev_wr_ready) begin
      rx_log[rx_n % 16] = dev_wr_data;
      rx_sum = rx_sum + 32'(dev_wr_data);
      rx_n++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic put_desc(int at, logic [31:0] addr, logic [15:0] cnt, bit last);
    mem[(at >> 1) + 0] = addr[15:0];
    mem[(at >> 1) + 1] = addr[31:16];
    mem[(at >> 1) + 2] = cnt;
    mem[(at >> 1) + 3] = last ? 16'h8000 : 16'h0000;
  endtask

  task automatic pulse_irq();
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
  endtask

  task automatic clear_counts();
    rx_n = 0; src_n = 0; wr_n = 0; fetch_n = 0; rx_sum = '0;
  endtask

  task automatic start(logic [31:0] tbl, bit dir);
    reg_write(3'd4, tbl);
    reg_write(3'd0, 32'h0);
    reg_write(3'd0, dir ? 32'h9 : 32'h1);
  endtask

  task automatic wait_moved(bit dir, int n, int limit);
    for (int i = 0; i < limit; i++) begin
      if ((dir ? wr_n : rx_n) >= n) break;
      @(negedge clk);
    end
  endtask

  task automatic run_single(bit dir, int w);
    logic [31:0] rd;
    int buf_a;
    buf_a = 32'h400 + w * 32'h40 + (dir ? 32'h200 : 32'h0);
    for (int k = 0; k < w; k++) mem[(buf_a >> 1) + k] = 16'h3000 + 16'(w * 16 + k);
    clear_counts();
    mem_delay = w - 1;
    snk_mode  = w % 2;
    src_en    = 1'b0;
    put_desc(32'h100, buf_a, 16'(2 * w), 1'b1);
    start(32'h100, dir);
    reg_read(3'd2, rd);
    check("R2 active after start", rd, 32'h81);
    src_en = dir;
    wait_moved(dir, w, 400);
    tick(2);
    pulse_irq();
    tick(2);
    reg_read(3'd2, rd);
    check("R7 good completion status", rd, 32'h84);
    check("R2 first descriptor word address", fetch_log[0], 32'h100);
    check("R2 second descriptor word address", fetch_log[1], 32'h104);
    if (dir) begin
      for (int k = 0; k < w; k++)
        check("R4 device word stored in memory", 32'(mem[(buf_a >> 1) + k]), 32'hA000 + 32'(k));
      check("R3 device words taken equal count/2", src_n, w);
    end else begin
      for (int k = 0; k < w; k++)
        check("R5 memory word delivered to device", 32'(rx_log[k]), 32'h3000 + 32'(w * 16 + k));
      check("R3 words delivered equal count/2", rx_n, w);
    end
    reg_write(3'd2, 32'h0);
    reg_read(3'd2, rd);
    check("R10 writing zero keeps flags", rd, 32'h84);
    reg_write(3'd2, 32'h4);
    reg_read(3'd2, rd);
    check("R10 write one clears interrupt flag", rd, 32'h80);
    src_en = 1'b0;
  endtask

  initial begin
    #950000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp_sum;
    for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 7 + 3);
    tick(4);
    rst = 1'b0;
    tick(2);

    reg_read(3'd0, rd);  check("R1 command after reset", rd, 32'h0);
    reg_read(3'd2, rd);  check("R12 simplex bit, idle status", rd, 32'h80);
    reg_read(3'd4, rd);  check("R1 pointer after reset", rd, 32'h0);
    reg_write(3'd4, 32'h0000_0103);
    reg_read(3'd4, rd);  check("R1 pointer low bits read zero", rd, 32'h100);

    // sweep: both directions, 1..4 words, varied wait states and back-pressure
    for (int d = 0; d < 2; d++)
      for (int w = 1; w <= 4; w++) run_single(d[0], w);

    // R6: two descriptors, device-to-memory
    clear_counts();
    mem_delay = 1;
    src_en    = 1'b0;
    put_desc(32'h180, 32'h900, 16'd6, 1'b0);
    put_desc(32'h188, 32'hA00, 16'd4, 1'b1);
    start(32'h180, 1'b1);
    src_en = 1'b1;
    wait_moved(1'b1, 5, 400);
    tick(2);
    pulse_irq();
    tick(2);
    reg_read(3'd2, rd);
    check("R6 chained table completes", rd, 32'h84);
    check("R6 next descriptor fetched 8 bytes on", fetch_log[2], 32'h188);
    check("R6 next descriptor second word", fetch_log[3], 32'h18C);
    check("R6 nothing moved past last descriptor", src_n, 5);
    check("R6 first region word 2", 32'(mem[(32'h900 >> 1) + 2]), 32'hA002);
    check("R6 second region word 0", 32'(mem[32'hA00 >> 1]), 32'hA003);
    check("R6 second region word 1", 32'(mem[(32'hA00 >> 1) + 1]), 32'hA004);
    src_en = 1'b0;
    reg_write(3'd2, 32'h4);

    // R8: interrupt before the table is used up
    clear_counts();
    mem_delay = 0;
    put_desc(32'h100, 32'h400, 16'd8, 1'b1);
    start(32'h100, 1'b1);
    tick(3);
    pulse_irq();
    tick(2);
    reg_read(3'd2, rd);
    check("R8 early interrupt gives error", rd, 32'h82);
    check("R8 nothing written", wr_n, 0);
    reg_write(3'd2, 32'h2);
    reg_read(3'd2, rd);
    check("R10 write one clears error flag", rd, 32'h80);

    // R9: table used up, interrupt never comes
    clear_counts();
    put_desc(32'h100, 32'h400, 16'd2, 1'b1);
    start(32'h100, 1'b1);
    src_en = 1'b1;
    wait_moved(1'b1, 1, 200);
    src_en = 1'b0;
    tick(IRQ_WAIT - 10);
    reg_read(3'd2, rd);
    check("R9 still waiting inside window", rd, 32'h81);
    tick(20);
    reg_read(3'd2, rd);
    check("R9 timeout gives error", rd, 32'h82);
    reg_write(3'd2, 32'h6);

    // R11: abort while the device stalls
    clear_counts();
    snk_mode = 2;
    put_desc(32'h100, 32'h400, 16'd8, 1'b1);
    start(32'h100, 1'b0);
    tick(10);
    reg_read(3'd0, rd);
    check("R1 command readback", rd, 32'h1);
    check("R5 word offered while device stalls", dev_wr_valid, 1'b1);
    reg_write(3'd0, 32'h0);
    tick(1);
    check("R11 memory request dropped", mem_req, 1'b0);
    check("R11 device offer dropped", dev_wr_valid, 1'b0);
    reg_read(3'd2, rd);
    check("R11 abort leaves no flags", rd, 32'h80);
    tick(IRQ_WAIT + 20);
    reg_read(3'd2, rd);
    check("R11 no late flag after abort", rd, 32'h80);
    check("R11 nothing delivered", rx_n, 0);

    // R3: count 0 moves 65536 bytes
    clear_counts();
    snk_mode = 0;
    put_desc(32'h100, 32'h0, 16'd0, 1'b1);
    exp_sum = '0;
    for (int i = 0; i < 4096; i++) exp_sum = exp_sum + 32'(mem[i]);
    exp_sum = exp_sum * 8;
    start(32'h100, 1'b0);
    wait_moved(1'b0, 32768, 150000);
    tick(2);
    pulse_irq();
    tick(2);
    reg_read(3'd2, rd);
    check("R3 zero-count table completes", rd, 32'h84);
    check("R3 zero count moves 32768 words", rx_n, 32768);
    check("R3 zero count data sum", rx_sum, exp_sum);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule